// File: doc/BRIEF.md
# Dual-Tone and Call-Progress Tone Synthesizer

This block synthesizes telephony signalling tones as a stream of signed linear samples at 8 kHz, running from a 2.048 MHz master clock. Every 256 clocks it emits one sample together with a one-cycle valid strobe. A mode input chooses between keypad dual-tone signalling and a set of call-progress tones. In dual-tone mode a 4-bit key index picks one low-group and one high-group frequency. The two sinusoids are summed, with the low-group tone set about 1.8 dB below the high-group tone. In call-progress mode a 5-bit code picks a single steady tone, or a warble that alternates between two frequencies at an 8 Hz rate. Codes that have no tone give silence.

Each frequency is made by a 16-bit phase accumulator. A constant increment is added to it once per sample. The top eight phase bits address a 64-entry quarter-wave magnitude table, and quadrant symmetry unfolds the table into a full sine. While the enable input is low the output is zero and both accumulators are held at zero, so every tone burst starts from the same phase. Gain scaling, companding and serial framing of the samples are handled downstream.

Top module: `tone_synth`

## Requirements
- R1: `sample_vld` is high for exactly one clock in every 256 clocks, and `sample_out` changes only in the cycle in which `sample_vld` is high.
- R2: While `rst_n` is low, `sample_out` is 0 and `sample_vld` is 0.
- R3: A sample whose tick finds `gen_en` low is 0, and both phase accumulators are cleared. The first sample after enabling is taken at phase 0 of every active tone.
- R4: Each tone uses a 16-bit phase accumulator. It advances once per sample by round(f × 65536 / 8000), which keeps every frequency well within ±1.5 % of nominal.
- R5: For phase p, let k = p[15:8]. A full-level tone sample is 4095 × sin(2π(k + 0.5)/256), within ±16.
- R6: When `dtmf_mode` is 1, `tone_code[3:2]` selects the low-group tone: 0 = 697 Hz, 1 = 770 Hz, 2 = 852 Hz, 3 = 941 Hz.
- R7: When `dtmf_mode` is 1, `tone_code[1:0]` selects the high-group tone: 0 = 1209 Hz, 1 = 1336 Hz, 2 = 1477 Hz, 3 = 1633 Hz. `tone_code[4]` has no effect.
- R8: A dual-tone sample is the full-level high-group sample plus 13/16 of a full-level low-group sample (about −1.8 dB), so |`sample_out`| never exceeds 7424.
- R9: When `dtmf_mode` is 0, these codes give one full-level tone: 9 = 400, 10 = 440, 11 = 480, 13 = 667, 14 = 800, 15 = 1000, 16 = 1200, 17 = 1300, 19 = 1477, 20 = 1633, 21 = 2000, 22 = 2100, 24 = 2400, 26 = 2500, 29 = 2700 and 31 = 3000 Hz. |`sample_out`| never exceeds 4095 in this mode.
- R10: When `dtmf_mode` is 0, these codes give warbles: 0 = 2730/2500 Hz, 1 = 2000/2667 Hz, 2 = 1000/1333 Hz. Counting from enable, the first frequency is used for samples 0–499 and the second for samples 500–999, and the pattern then repeats. The phase stays continuous across each switch.
- R11: When `dtmf_mode` is 0, codes 3–8, 12, 18, 23, 25, 27, 28 and 30 give zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable; low gives silence and clears phases |
| dtmf_mode | input | 1 | 1 = dual-tone keypad mode, 0 = call-progress mode |
| tone_code | input | 5 | Key index or call-progress tone code |
| sample_out | output | 14 | Signed linear tone sample |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
The checker watches on every cycle that the strobe is a single-cycle pulse with a period of exactly 256 clocks. It also checks that the output holds between strobes, that a disabled tick or an unassigned call-progress code yields zero, and that the output stays within the dual-tone and single-tone magnitude bounds. The correct frequency selection, the zero-phase start, the 13/16 low-group weighting, the sine shape and the 500-sample warble switch can only be seen by comparing whole sample sequences against a reference model. The bench scenarios do this for several keys, single tones, a silent code and a full warble switch.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    KIND_MUTE = 2'd0,
    KIND_ONE  = 2'd1,
    KIND_TWO  = 2'd2
  } tone_kind_e;

  // Phase increment for frequency f at sample rate fs with an acc_w-bit accumulator, rounded.
  function automatic logic [31:0] tone_inc(int unsigned f_hz, int unsigned fs_hz,
                                           int unsigned acc_w);
    longint num;
    num = (longint'(f_hz) << acc_w) + longint'(fs_hz / 2);
    return 32'(num / longint'(fs_hz));
  endfunction

  // Quarter-wave magnitude at entry i of a 2**aw table, sampled at bin centres.
  // Uses a rational sine approximation evaluated in degrees.
  function automatic int unsigned quarter_mag(int unsigned i, int unsigned aw,
                                              int unsigned peak);
    longint n2, span, u, p, den, num;
    n2   = longint'(2) << aw;
    span = 180 * n2;
    u    = longint'(2 * i + 1) * 90;
    p    = u * (span - u);
    den  = longint'(40500) * n2 * n2 - p;
    num  = longint'(peak) * 4 * p;
    return int'((num + den / 2) / den);
  endfunction

  // Call-progress codes that produce a tone.
  function automatic logic progress_code_used(logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd2, 5'd9, 5'd10, 5'd11, 5'd13, 5'd14, 5'd15, 5'd16, 5'd17,
      5'd19, 5'd20, 5'd21, 5'd22, 5'd24, 5'd26, 5'd29, 5'd31: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tone_tick_gen.sv
module tone_tick_gen #(
  parameter int DIV = 256,
  localparam int CW = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tone_warble_timer.sv
module tone_warble_timer #(
  parameter int HALF = 500,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic sel
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (clr) begin
      cnt_d = '0;
      sel_d = 1'b0;
    end else if (adv) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      sel_d = wrap ? ~sel_q : sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/tone_freq_sel.sv
module tone_freq_sel
  import tone_pkg::*;
#(
  parameter int FS_HZ = 8000,
  parameter int ACC_W = 16
) (
  input  logic             dtmf_mode,
  input  logic [4:0]       code,
  input  logic             warble_sel,
  output logic [ACC_W-1:0] inc_hi,
  output logic [ACC_W-1:0] inc_lo,
  output tone_kind_e       kind
);
  function automatic logic [ACC_W-1:0] inc(int unsigned f);
    return ACC_W'(tone_inc(f, FS_HZ, ACC_W));
  endfunction

  always_comb begin
    inc_hi = '0;
    inc_lo = '0;
    kind   = KIND_MUTE;
    if (dtmf_mode) begin
      kind = KIND_TWO;
      case (code[3:2])
        2'd0:    inc_lo = inc(697);
        2'd1:    inc_lo = inc(770);
        2'd2:    inc_lo = inc(852);
        default: inc_lo = inc(941);
      endcase
      case (code[1:0])
        2'd0:    inc_hi = inc(1209);
        2'd1:    inc_hi = inc(1336);
        2'd2:    inc_hi = inc(1477);
        default: inc_hi = inc(1633);
      endcase
    end else begin
      kind = KIND_ONE;
      case (code)
        5'd0:    inc_hi = warble_sel ? inc(2500) : inc(2730);
        5'd1:    inc_hi = warble_sel ? inc(2667) : inc(2000);
        5'd2:    inc_hi = warble_sel ? inc(1333) : inc(1000);
        5'd9:    inc_hi = inc(400);
        5'd10:   inc_hi = inc(440);
        5'd11:   inc_hi = inc(480);
        5'd13:   inc_hi = inc(667);
        5'd14:   inc_hi = inc(800);
        5'd15:   inc_hi = inc(1000);
        5'd16:   inc_hi = inc(1200);
        5'd17:   inc_hi = inc(1300);
        5'd19:   inc_hi = inc(1477);
        5'd20:   inc_hi = inc(1633);
        5'd21:   inc_hi = inc(2000);
        5'd22:   inc_hi = inc(2100);
        5'd24:   inc_hi = inc(2400);
        5'd26:   inc_hi = inc(2500);
        5'd29:   inc_hi = inc(2700);
        5'd31:   inc_hi = inc(3000);
        default: kind   = KIND_MUTE;
      endcase
    end
  end
endmodule

// File: rtl/tone_sine_lut.sv
module tone_sine_lut
  import tone_pkg::*;
#(
  parameter int LUT_AW = 6,
  parameter int MAG_W  = 12,
  localparam int DEPTH = 1 << LUT_AW,
  localparam int PEAK  = (1 << MAG_W) - 1
) (
  input  logic [LUT_AW+1:0]       phase_top,
  output logic signed [MAG_W:0]   wave
);
  logic [MAG_W-1:0]  rom [DEPTH];
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, addr;
  logic [MAG_W-1:0]  mag;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = MAG_W'(quarter_mag(g, LUT_AW, PEAK));
  end

  always_comb begin
    quad = phase_top[LUT_AW+1:LUT_AW];
    idx  = phase_top[LUT_AW-1:0];
    addr = quad[0] ? ~idx : idx;
    mag  = rom[addr];
    wave = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tone_pkg::*;
#(
  parameter int CLK_HZ    = 2048000,
  parameter int FS_HZ     = 8000,
  parameter int WARBLE_HZ = 8,
  parameter int ACC_W     = 16,
  parameter int LUT_AW    = 6,
  parameter int MAG_W     = 12,
  localparam int OUT_W    = MAG_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gen_en,
  input  logic                    dtmf_mode,
  input  logic [4:0]              tone_code,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_vld
);
  localparam int DIV  = CLK_HZ / FS_HZ;
  localparam int HALF = FS_HZ / (2 * WARBLE_HZ);
  localparam int TW   = LUT_AW + 2;
  localparam int SW   = MAG_W + 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic             tick;
  logic             warble_sel;
  logic [ACC_W-1:0] inc_hi, inc_lo;
  tone_kind_e       kind;

  tone_tick_gen #(.DIV(DIV)) i_tick (
    .clk(clk), .rst_n(rst_i_n), .tick(tick)
  );

  tone_warble_timer #(.HALF(HALF)) i_warble (
    .clk(clk), .rst_n(rst_i_n), .clr(!gen_en), .adv(tick), .sel(warble_sel)
  );

  tone_freq_sel #(.FS_HZ(FS_HZ), .ACC_W(ACC_W)) i_sel (
    .dtmf_mode(dtmf_mode), .code(tone_code), .warble_sel(warble_sel),
    .inc_hi(inc_hi), .inc_lo(inc_lo), .kind(kind)
  );

  // Phase accumulators
  logic [ACC_W-1:0] ph_hi_q, ph_hi_d, ph_lo_q, ph_lo_d;

  always_comb begin
    ph_hi_d = ph_hi_q;
    ph_lo_d = ph_lo_q;
    if (!gen_en) begin
      ph_hi_d = '0;
      ph_lo_d = '0;
    end else if (tick) begin
      ph_hi_d = ph_hi_q + inc_hi;
      ph_lo_d = ph_lo_q + inc_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ph_hi_q <= '0;
      ph_lo_q <= '0;
    end else begin
      ph_hi_q <= ph_hi_d;
      ph_lo_q <= ph_lo_d;
    end
  end

  // Sine conversion
  logic signed [SW-1:0] wave_hi, wave_lo;

  tone_sine_lut #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) i_lut_hi (
    .phase_top(ph_hi_q[ACC_W-1 -: TW]), .wave(wave_hi)
  );
  tone_sine_lut #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) i_lut_lo (
    .phase_top(ph_lo_q[ACC_W-1 -: TW]), .wave(wave_lo)
  );

  // Group weighting and mixing: low group at 13/16 of full level
  logic signed [SW-1:0]    lo_w;
  logic signed [OUT_W-1:0] mix, smp_d, smp_q;
  logic                    vld_q;

  always_comb begin
    lo_w = wave_lo - (wave_lo >>> 3) - (wave_lo >>> 4);
    case (kind)
      KIND_ONE: mix = OUT_W'(wave_hi);
      KIND_TWO: mix = OUT_W'(wave_hi) + OUT_W'(lo_w);
      default:  mix = '0;
    endcase
    smp_d = gen_en ? mix : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) smp_q <= smp_d;
    end
  end

  assign sample_out = smp_q;
  assign sample_vld = vld_q;
endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk
  import tone_pkg::*;
#(
  parameter int CLK_HZ = 2048000,
  parameter int FS_HZ  = 8000,
  parameter int MAG_W  = 12,
  localparam int OUT_W = MAG_W + 2,
  localparam int DIV   = CLK_HZ / FS_HZ,
  localparam int PEAK  = (1 << MAG_W) - 1,
  localparam int GW    = $clog2(DIV) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    gen_en,
  input logic                    dtmf_mode,
  input logic [4:0]              tone_code,
  input logic signed [OUT_W-1:0] sample_out,
  input logic                    sample_vld
);
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sample_vld) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R1
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && seen_q) |-> (gap_q == GW'(DIV - 1)));

  // R1
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> $stable(sample_out));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !$past(gen_en)) |-> (sample_out == '0));

  // R11
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !$past(dtmf_mode) && !progress_code_used($past(tone_code)))
      |-> (sample_out == '0));

  // R8
  dual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out <= OUT_W'(7424)) && (sample_out >= -OUT_W'(7424)));

  // R9
  single_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !$past(dtmf_mode))
      |-> ((sample_out <= OUT_W'(PEAK)) && (sample_out >= -OUT_W'(PEAK))));
endmodule

bind tone_synth tone_synth_chk #(.CLK_HZ(CLK_HZ), .FS_HZ(FS_HZ), .MAG_W(MAG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .dtmf_mode(dtmf_mode),
  .tone_code(tone_code), .sample_out(sample_out), .sample_vld(sample_vld)
);

// File: tb/test_tone_synth.sv
`timescale 1ns/1ps
module test_tone_synth;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               gen_en;
  logic               dtmf_mode;
  logic [4:0]         tone_code;
  logic signed [13:0] sample_out;
  logic               sample_vld;

  always #2 clk = ~clk;

  tone_synth i_tone_synth (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .dtmf_mode(dtmf_mode),
    .tone_code(tone_code), .sample_out(sample_out), .sample_vld(sample_vld)
  );

  typedef struct { int val; int tol; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int pha = 0, phb = 0, wcnt = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp, int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real row_f(int i);
    case (i) 0: return 697.0; 1: return 770.0; 2: return 852.0; default: return 941.0; endcase
  endfunction
  function automatic real col_f(int i);
    case (i) 0: return 1209.0; 1: return 1336.0; 2: return 1477.0; default: return 1633.0; endcase
  endfunction
  function automatic real prog_f(int c, bit sel);
    case (c)
      0: return sel ? 2500.0 : 2730.0;
      1: return sel ? 2667.0 : 2000.0;
      2: return sel ? 1333.0 : 1000.0;
      9: return 400.0;  10: return 440.0;  11: return 480.0;  13: return 667.0;
      14: return 800.0; 15: return 1000.0; 16: return 1200.0; 17: return 1300.0;
      19: return 1477.0; 20: return 1633.0; 21: return 2000.0; 22: return 2100.0;
      24: return 2400.0; 26: return 2500.0; 29: return 2700.0; 31: return 3000.0;
      default: return 0.0;
    endcase
  endfunction
  function automatic int incr(real f);
    return int'($floor(f * 65536.0 / 8000.0 + 0.5));
  endfunction
  function automatic int sinv(int p, real w);
    int k;
    k = (p >> 8) & 255;
    return int'($floor(w * 4095.0 * $sin(2.0 * 3.14159265358979 * (k + 0.5) / 256.0) + 0.5));
  endfunction

  task automatic push(bit en, bit mode, logic [4:0] code, string req);
    exp_t e;
    bit sel;
    real f;
    e.req = req;
    if (!en) begin
      e.val = 0; e.tol = 0;
      pha = 0; phb = 0; wcnt = 0;
    end else begin
      sel = ((wcnt / 500) % 2) == 1;
      wcnt++;
      if (mode) begin
        e.val = sinv(pha, 1.0) + sinv(phb, 0.8125);
        e.tol = 16;
        pha = (pha + incr(col_f(int'(code[1:0])))) & 16'hFFFF;
        phb = (phb + incr(row_f(int'(code[3:2])))) & 16'hFFFF;
      end else begin
        f = prog_f(int'(code), sel);
        if (f == 0.0) begin
          e.val = 0; e.tol = 0;
        end else begin
          e.val = sinv(pha, 1.0); e.tol = 16;
          pha = (pha + incr(f)) & 16'hFFFF;
        end
      end
    end
    q.push_back(e);
  endtask

  task automatic wait_vld();
    @(negedge clk);
    while (!sample_vld) @(negedge clk);
  endtask

  task automatic apply(bit en, bit mode, logic [4:0] code, int n, string req);
    gen_en = en; dtmf_mode = mode; tone_code = code;
    for (int i = 0; i < n; i++) push(en, mode, code, req);
    repeat (n) wait_vld();
    #1;
  endtask

  // Monitor: pops expected samples, checks strobe period and hold
  int cyc = 0, last_vld = -1, last_smp = 0;
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (sample_vld) begin
      if (last_vld >= 0) check("R1 period", cyc - last_vld, 256, 0);
      last_vld = cyc;
      last_smp = int'(sample_out);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.req, int'(sample_out), e.val, e.tol);
      end
    end else if (last_vld >= 0 && cyc - last_vld == 128) begin
      check("R1 hold", int'(sample_out), last_smp, 0);
    end
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gen_en = 1'b0; dtmf_mode = 1'b0; tone_code = 5'd0;
    repeat (5) @(negedge clk);
    check("R2 reset sample", int'(sample_out), 0, 0);
    check("R2 reset strobe", int'(sample_vld), 0, 0);
    rst_n = 1'b1;
    wait_vld();
    #1;
    apply(0, 0, 5'd0,      3,   "R3 disabled");
    apply(1, 1, 5'b00000,  8,   "R4 R5 R6 R8 key 697+1209");
    apply(1, 1, 5'b00101,  8,   "R6 R7 R8 key 770+1336");
    apply(1, 1, 5'b11010,  8,   "R7 bit4 ignored 852+1477");
    apply(1, 1, 5'b01111,  8,   "R6 R7 key 941+1633");
    apply(1, 0, 5'd9,      8,   "R9 400 Hz");
    apply(1, 0, 5'd31,     8,   "R9 3000 Hz");
    apply(1, 0, 5'd3,      4,   "R11 unassigned");
    apply(0, 0, 5'd0,      2,   "R3 disabled");
    apply(1, 0, 5'd2,      505, "R10 warble 1000/1333");
    apply(0, 1, 5'd0,      2,   "R3 disabled");
    apply(1, 1, 5'b00000,  4,   "R3 zero-phase restart");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule